// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Dead-Band

This block generates two pulse-width-modulated outputs from a single triangle counter. The counter climbs from zero to a programmable turn-around value and falls back to zero. Two compare values, A and B, are checked against it on every clock. Each raw output is high while the counter is strictly above its compare value, so every pulse is centred on the turn-around point. A dead-band stage then shapes the final outputs. When it is off, the two outputs are independent. When it is on, output B is no longer driven by compare B. It becomes the complement of output A, and each output's leading edge is held back by its own delay, so the two outputs can never be high together.

All settings arrive on a single write strobe: turn-around value, both compare values, both delays and the dead-band enable. They land in a holding copy first. The update mode given with the write decides when the holding copy becomes the working copy. An immediate write takes effect on the next clock. A zero-point write waits for the next counter zero. A synchronised write waits for the first counter zero that follows a global strobe. A pulse on `zero_evt` marks each counter zero, once per period, so software can time its writes.

Top module: `pwm_db_gen`

## Requirements
- R1: With a working turn-around value L ≥ 1, the counter runs 0,1,…,L,L-1,…,1,0 and `zero_evt` is high for exactly one cycle in every 2·L cycles.
- R2: With dead-band off, each output is high for 2·(L−C)−1 cycles per period when its compare value C < L, and is never high when C ≥ L. The two outputs do not affect each other.
- R3: With dead-band off and equal compare values, the two outputs are identical on every cycle.
- R4: With dead-band on, output B ignores compare B and is derived only from raw output A. The two outputs are never high in the same cycle. With both delays zero, B is the exact complement of A.
- R5: With dead-band on, output A rises a number of cycles after raw A rises equal to the rising delay, and falls with it. Its high time is max(0, W−rise), where W is raw A's high time, so a pulse shorter than the delay disappears.
- R6: With dead-band on, output B rises a number of cycles after raw A falls equal to the falling delay, and falls when raw A rises. Its high time is max(0, 2·L−W−fall).
- R7: A write in mode 0 (immediate) becomes the working setting on the clock edge that samples it.
- R8: A write in mode 1 (zero point), or in mode 3, becomes the working setting only at the next cycle in which the counter is zero.
- R9: A write in mode 2 (synchronised) becomes the working setting at the first counter zero that follows a `gsync` pulse issued in or after the write's cycle. A `gsync` pulse with no synchronised write pending has no effect.
- R10: A write that arrives in the same cycle as a commit, or after it, is kept and committed by its own mode's rule. It is never lost.
- R11: During reset and just after it, both outputs are low, `zero_evt` is high, and the turn-around value is `DEF_LOAD` with dead-band off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for all setting fields |
| wr_load | input | 16 | Counter turn-around value L |
| wr_cmp_a | input | 16 | Compare value for channel A |
| wr_cmp_b | input | 16 | Compare value for channel B |
| wr_rise | input | 8 | Leading-edge delay for output A, in cycles |
| wr_fall | input | 8 | Leading-edge delay for output B, in cycles |
| wr_db_en | input | 1 | Dead-band enable (couples B to A) |
| wr_mode | input | 2 | Commit mode: 0 immediate, 1 zero point, 2 synchronised, 3 as 1 |
| gsync | input | 1 | Global synchronise strobe |
| zero_evt | output | 1 | High in the cycle the counter is zero |
| pwm_a | output | 1 | Final output A |
| pwm_b | output | 1 | Final output B |

## Verification
A commit and a new write can land in the same cycle. This happens when a zero-point write is pending and software writes again at the counter zero that commits it. The bench provokes this by issuing the second write in the very cycle `zero_evt` is high. It then measures the next two zero-to-zero intervals: the first must reflect the earlier write's turn-around value, and the second the later one. Synchronised commits are judged the same way, by interval length, before and after a strobe placed in mid-period.

// File: rtl/pwm_db_pkg.sv
// Shared widths, commit-mode encoding and the setting record of the PWM generator.
package pwm_db_pkg;
    parameter int CNT_W = 16;   // counter and compare width
    parameter int DLY_W = 8;    // dead-band delay width

    typedef enum logic [1:0] {
        UPD_IMM    = 2'd0,
        UPD_ZERO   = 2'd1,
        UPD_GLOBAL = 2'd2,
        UPD_RSVD   = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [DLY_W-1:0] rise;
        logic [DLY_W-1:0] fall;
        logic             db_en;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_updown_counter.sv
// Triangle counter: counts 0..load..0, repeating with period 2*load.
// Assumes: a load of zero parks the counter at zero. A load lowered below the
// current count while climbing turns the counter around at once.
module pwm_updown_counter #(
    parameter int CW = pwm_db_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] load,
    output logic [CW-1:0] cnt,
    output logic          zero
);
    logic dir_up;

    // Step the counter and reverse direction at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (load == '0) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (dir_up) begin
            if (cnt >= load) begin
                dir_up <= 1'b0;
                cnt    <= cnt - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                dir_up <= 1'b1;
                cnt    <= cnt + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign zero = (cnt == '0);

    AST_ZERO_THEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && load != '0) |=> (cnt == CW'(1)));  // R1
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero && load != '0) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));  // R1
endmodule

// File: rtl/pwm_cfg_commit.sv
// Holding and working copies of the generator settings, plus the commit rules.
// Assumes: mode 0 applies on the next edge, modes 1 and 3 at the next counter
// zero, and mode 2 at the first counter zero after a gsync issued in or after the write's cycle.
module pwm_cfg_commit
    import pwm_db_pkg::*;
#(
    parameter int DEF_LOAD = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  pwm_cfg_t wr_cfg,
    input  logic [1:0] wr_mode,
    input  logic     gsync,
    input  logic     zero,
    output pwm_cfg_t active
);
    localparam pwm_cfg_t RST_CFG = '{
        load:  CNT_W'(DEF_LOAD),
        cmp_a: CNT_W'(DEF_LOAD),
        cmp_b: CNT_W'(DEF_LOAD),
        rise:  '0,
        fall:  '0,
        db_en: 1'b0
    };

    pwm_cfg_t shadow;
    logic     pend;
    logic     pend_glb;
    logic     armed;
    logic     commit;
    logic     wr_imm;
    logic     wr_glb;

    // Decode the mode that comes with this write.
    assign wr_imm = (wr_mode == UPD_IMM);
    assign wr_glb = (wr_mode == UPD_GLOBAL);
    // A pending update transfers at a counter zero, once armed if synchronised.
    assign commit = pend && zero && (!pend_glb || armed);

    // Hold writes, arm on the global strobe, and transfer on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= RST_CFG;
            shadow   <= RST_CFG;
            pend     <= 1'b0;
            pend_glb <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (commit) begin
                active <= shadow;
                pend   <= 1'b0;
                armed  <= 1'b0;
            end else if (gsync && pend && pend_glb) begin
                armed <= 1'b1;
            end
            if (wr_en) begin
                shadow <= wr_cfg;
                if (wr_imm) begin
                    active <= wr_cfg;
                    pend   <= 1'b0;
                    armed  <= 1'b0;
                end else begin
                    pend     <= 1'b1;
                    pend_glb <= wr_glb;
                    armed    <= wr_glb && gsync;
                end
            end
        end
    end

    AST_IMM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_imm) |=> (active == $past(wr_cfg)));  // R7
    AST_HOLD_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !zero) |=> $stable(active));  // R8
    AST_GLOBAL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && pend_glb && !armed && !(wr_en && wr_imm)) |=> $stable(active));  // R9
endmodule

// File: rtl/pwm_compare.sv
// One comparator: registered output, high while the counter exceeds the compare value.
// Assumes: compare and counter share one width; the output lags the count by one cycle.
module pwm_compare #(
    parameter int CW = pwm_db_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    output logic          raw
);
    // Compare the counter with the compare value on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= 1'b0;
        else        raw <= (cnt > cmp);
    end
endmodule

// File: rtl/pwm_edge_delay.sv
// Leading-edge delay: the output follows the input down at once and up only after
// the input has been high for dly cycles. A shorter pulse is dropped.
// Assumes: x_in and dly come from registers, so the output cannot glitch.
module pwm_edge_delay #(
    parameter int DW = pwm_db_pkg::DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_in,
    input  logic [DW-1:0] dly,
    output logic          y_out
);
    logic [DW-1:0] run;

    // Count the cycles the input has been high, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (!x_in)      run <= '0;
        else if (run != '1)  run <= run + 1'b1;
    end

    assign y_out = x_in && (run >= dly);

    AST_FRONT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in && !$past(x_in) && dly != '0) |-> !y_out);  // R5
endmodule

// File: rtl/pwm_db_gen.sv
// Center-aligned PWM generator: one triangle counter, two comparators, and a
// dead-band stage that, when enabled, turns B into the delayed complement of A.
// Assumes: all settings pass through pwm_cfg_commit, and zero_evt marks counter zero.
module pwm_db_gen
    import pwm_db_pkg::*;
#(
    parameter int DEF_LOAD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_load,
    input  logic [CNT_W-1:0] wr_cmp_a,
    input  logic [CNT_W-1:0] wr_cmp_b,
    input  logic [DLY_W-1:0] wr_rise,
    input  logic [DLY_W-1:0] wr_fall,
    input  logic             wr_db_en,
    input  logic [1:0]       wr_mode,
    input  logic             gsync,
    output logic             zero_evt,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int NCH = 2;

    pwm_cfg_t         wr_cfg;
    pwm_cfg_t         act;
    logic [CNT_W-1:0] cnt;
    logic             zero;
    logic [CNT_W-1:0] cmp_v [NCH];
    logic             raw_v [NCH];
    logic             x_v   [NCH];
    logic [DLY_W-1:0] d_v   [NCH];
    logic             y_v   [NCH];

    // Gather the write fields into one record.
    always_comb begin
        wr_cfg.load  = wr_load;
        wr_cfg.cmp_a = wr_cmp_a;
        wr_cfg.cmp_b = wr_cmp_b;
        wr_cfg.rise  = wr_rise;
        wr_cfg.fall  = wr_fall;
        wr_cfg.db_en = wr_db_en;
    end

    pwm_cfg_commit #(.DEF_LOAD(DEF_LOAD)) u_commit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
        .wr_mode(wr_mode), .gsync(gsync), .zero(zero), .active(act)
    );

    pwm_updown_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(act.load), .cnt(cnt), .zero(zero)
    );

    assign cmp_v[0] = act.cmp_a;
    assign cmp_v[1] = act.cmp_b;

    // Dead-band routing: B takes inverted raw A and the falling delay when enabled.
    always_comb begin
        x_v[0] = raw_v[0];
        d_v[0] = act.db_en ? act.rise : '0;
        x_v[1] = act.db_en ? !raw_v[0] : raw_v[1];
        d_v[1] = act.db_en ? act.fall : '0;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_compare #(.CW(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp_v[ch]), .raw(raw_v[ch])
        );
        pwm_edge_delay #(.DW(DLY_W)) u_dly (
            .clk(clk), .rst_n(rst_n), .x_in(x_v[ch]), .dly(d_v[ch]), .y_out(y_v[ch])
        );
    end

    assign zero_evt = zero;
    assign pwm_a    = y_v[0];
    assign pwm_b    = y_v[1];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        act.db_en |-> !(pwm_a && pwm_b));  // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b && zero_evt));  // R11
endmodule

// File: tb/tb_pwm_db_gen.sv
module tb_pwm_db_gen;
    import pwm_db_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [CNT_W-1:0] wr_load = '0;
    logic [CNT_W-1:0] wr_cmp_a = '0;
    logic [CNT_W-1:0] wr_cmp_b = '0;
    logic [DLY_W-1:0] wr_rise = '0;
    logic [DLY_W-1:0] wr_fall = '0;
    logic             wr_db_en = 1'b0;
    logic [1:0]       wr_mode = 2'd0;
    logic             gsync = 1'b0;
    logic             zero_evt, pwm_a, pwm_b;

    int tests = 0;
    int fails = 0;

    pwm_db_gen #(.DEF_LOAD(16)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_load(wr_load),
        .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b), .wr_rise(wr_rise),
        .wr_fall(wr_fall), .wr_db_en(wr_db_en), .wr_mode(wr_mode),
        .gsync(gsync), .zero_evt(zero_evt), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges up to and including the next one with zero_evt high; releases strobes.
    task automatic measure_interval(output int n);
        n = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            gsync = 1'b0;
            n++;
        end while (!zero_evt);
    endtask

    task automatic post_write(input int mode, input int ld, input int ca, input int cb,
                              input int rs, input int fl, input bit db);
        wr_en    = 1'b1;
        wr_mode  = mode[1:0];
        wr_load  = CNT_W'(ld);
        wr_cmp_a = CNT_W'(ca);
        wr_cmp_b = CNT_W'(cb);
        wr_rise  = DLY_W'(rs);
        wr_fall  = DLY_W'(fl);
        wr_db_en = db;
    endtask

    function automatic int raw_w(input int L, input int c);
        return (c >= L) ? 0 : 2 * (L - c) - 1;
    endfunction

    function automatic int clamp0(input int v);
        return (v < 0) ? 0 : v;
    endfunction

    // Apply immediately at a counter zero, settle two periods, then count one period.
    task automatic run_duty(input string req, input int L, input int ca, input int cb,
                            input int rs, input int fl, input bit db);
        int n, ha, hb, ov, df, wa, ea, eb;
        measure_interval(n);
        post_write(0, L, ca, cb, rs, fl, db);
        measure_interval(n);
        measure_interval(n);
        ha = 0; hb = 0; ov = 0; df = 0;
        for (int i = 0; i < 2 * L; i++) begin
            @(negedge clk);
            ha += pwm_a;
            hb += pwm_b;
            ov += (pwm_a && pwm_b);
            df += (pwm_a != pwm_b);
        end
        wa = raw_w(L, ca);
        if (db) begin
            ea = clamp0(wa - rs);
            eb = (wa == 0) ? 2 * L : clamp0(2 * L - wa - fl);
            check({req, " A high time"}, ha, ea);
            check({req, " B high time"}, hb, eb);
            check("R4 no overlap", ov, 0);
        end else begin
            check({req, " A high time"}, ha, wa);
            check({req, " B high time"}, hb, raw_w(L, cb));
            if (ca == cb) check("R3 identical outputs", df, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 pwm_a in reset", pwm_a, 0);
        check("R11 pwm_b in reset", pwm_b, 0);
        check("R11 zero_evt in reset", zero_evt, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_period();
        int n;
        measure_interval(n);
        measure_interval(n);
        check("R1 default period", n, 32);
        check("R11 default load", n, 2 * 16);
    endtask

    task automatic t_duty();
        run_duty("R2 independent", 20, 5, 12, 0, 0, 1'b0);
        run_duty("R2 above/zero compare", 20, 25, 0, 0, 0, 1'b0);
        run_duty("R3 equal compares", 20, 8, 8, 0, 0, 1'b0);
        run_duty("R4 zero delays, B ignores cmp_b", 20, 10, 3, 0, 0, 1'b1);
        run_duty("R5 R6 both delays", 20, 10, 3, 3, 5, 1'b1);
        run_duty("R5 rise suppresses", 20, 18, 0, 5, 0, 1'b1);
        run_duty("R6 fall suppresses", 20, 2, 0, 0, 7, 1'b1);
        run_duty("R2 back to independent", 20, 25, 25, 0, 0, 1'b0);
    endtask

    task automatic t_immediate();
        int n;
        measure_interval(n);
        post_write(0, 10, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R7 immediate shortens period", n, 20);
        post_write(0, 20, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R7 immediate restores period", n, 40);
    endtask

    task automatic t_zero();
        int n;
        post_write(1, 10, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R8 old period kept until zero", n, 40);
        measure_interval(n);
        check("R8 new period after zero", n, 20);
        post_write(3, 20, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R8 mode 3 waits for zero", n, 20);
        measure_interval(n);
        check("R8 mode 3 applied", n, 40);
    endtask

    task automatic t_coincide();
        int n;
        post_write(1, 10, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R8 pending before coincident write", n, 40);
        post_write(1, 15, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R10 commit in write cycle uses earlier value", n, 20);
        measure_interval(n);
        check("R10 write in commit cycle kept", n, 30);
        post_write(0, 20, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R7 restore", n, 40);
    endtask

    task automatic t_global();
        int n;
        gsync = 1'b1;
        measure_interval(n);
        check("R9 stray strobe, period unchanged", n, 40);
        post_write(2, 10, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R9 no strobe yet, first period", n, 40);
        measure_interval(n);
        check("R9 earlier strobe does not arm", n, 40);
        for (int i = 0; i < 5; i++) @(negedge clk);
        gsync = 1'b1;
        measure_interval(n);
        check("R9 strobe mid-period, commit at next zero", n, 35);
        measure_interval(n);
        check("R9 synchronised value applied", n, 20);
        post_write(1, 15, 25, 25, 0, 0, 1'b0);
        measure_interval(n);
        check("R10 write after commit waits", n, 20);
        measure_interval(n);
        check("R10 write after commit kept", n, 30);
    endtask

    initial begin
        t_reset();
        t_period();
        t_duty();
        t_immediate();
        t_zero();
        t_coincide();
        t_global();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule